// File: doc/BRIEF.md
# Loadable Twisted-Ring Counter

This block is a twisted-ring counter, also called a Johnson counter. Its register is WIDTH bits wide, with a default of 4. On every rising clock edge the word moves one place toward the most significant bit. The inverse of the top bit goes into bit 0, so a run of ones grows through the register and then a run of zeros follows it. A WIDTH-bit counter visits 2·WIDTH codes before it repeats. Each code differs from the one before it in exactly one bit.

Two active-low controls act on the register:
- **Clear** is asynchronous and forces all zeros at once.
- **Preset** is synchronous. When it is low at a rising edge, the register takes a parallel value.

That parallel value can be any word. If it is not one of the 2·WIDTH legal codes, the counter moves it with the same shift rule and never corrects it. The word then circulates in a cycle of its own.

Top module: `twisted_ring_counter`

## Requirements
- R1: When clrN goes low, countOut becomes all zeros at once, without waiting for a clock edge, and stays zero while clrN is low.
- R2: Clear has priority over preset and over shifting. While clrN is low, rising edges with presetN low and any loadVal leave countOut at zero.
- R3: With clrN high, if presetN is low at a rising edge, countOut takes loadVal on that edge.
- R4: With clrN and presetN both high, each rising edge gives countOut[0] = ~countOut[WIDTH-1] and countOut[i] = countOut[i-1] for i from 1 to WIDTH-1.
- R5: At WIDTH=4, starting from 0000, the edges give 0001, 0011, 0111, 1111, 1110, 1100, 1000 and then 0000.
- R6: From any loaded word, 2·WIDTH consecutive shifts bring countOut back to that same word.
- R7: An illegal loaded word is shifted with no correction. At WIDTH=4, 0101 steps through 1011, 0110, 1101, 1010, 0100, 1001, 0010 and then back to 0101.
- R8: After clrN is released between edges, the first rising edge with presetN high gives 0…01.
- R9: Preset has priority over shifting. While presetN stays low, countOut follows loadVal on every edge and does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clrN | input | 1 | Asynchronous clear, active low |
| presetN | input | 1 | Synchronous parallel load enable, active low |
| loadVal | input | WIDTH | Parallel word taken in while presetN is low |
| countOut | output | WIDTH | Current register word |

## Verification
The shift rule is tried with three kinds of starting pattern:
- **From the zero state.** The eight-code walk from zero covers every legal code. It shows whether the inverted feedback and the direction of the shift are right.
- **From an alternating illegal seed.** This pattern only repeats after eight steps if the feedback inverts and the register applies no fix-up. Any code-correcting logic would pull it into the legal set.
- **With preset held low across several edges, and with clear dropped part-way through a period.** The held preset tells load apart from shift. The mid-period clear, held across edges while preset is low, shows whether clear is asynchronous and whether it wins over load.

// File: rtl/ring_pkg.sv
package ring_pkg;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic loadEn;   // take the parallel word
    logic shiftEn;  // advance the twisted ring
  } ringStrobe_t;

endpackage

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import ring_pkg::*;
(
  input  logic        presetN,
  output ringStrobe_t strobe
);

  // Preset outranks the shift; exactly one strobe is active per cycle
  always_comb begin
    strobe.loadEn  = ~presetN;
    strobe.shiftEn = presetN;
  end

endmodule

// File: rtl/ring_datapath.sv
module ring_datapath
  import ring_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clrN,
  input  ringStrobe_t      strobe,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] countQ
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] shiftIn;
  logic [WIDTH-1:0] nextQ;

  // Each stage takes its lower neighbour; stage 0 takes the inverted top stage
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_feedback
      assign shiftIn[i] = ~countQ[LAST];
    end else begin : g_link
      assign shiftIn[i] = countQ[i-1];
    end
  end

  always_comb begin
    nextQ = countQ;
    if (strobe.loadEn) begin
      nextQ = loadVal;
    end else if (strobe.shiftEn) begin
      nextQ = shiftIn;
    end
  end

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      countQ <= '0;
    end else begin
      countQ <= nextQ;
    end
  end

endmodule

// File: rtl/twisted_ring_counter.sv
module twisted_ring_counter
  import ring_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clrN,
  input  logic             presetN,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] countOut
);

  ringStrobe_t strobe;

  ring_ctrl ctrl_i (
    .presetN (presetN),
    .strobe  (strobe)
  );

  ring_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk     (clk),
    .clrN    (clrN),
    .strobe  (strobe),
    .loadVal (loadVal),
    .countQ  (countOut)
  );

endmodule

// File: rtl/twisted_ring_counter_chk.sv
module twisted_ring_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clrN,
  input logic             presetN,
  input logic [WIDTH-1:0] loadVal,
  input logic [WIDTH-1:0] countOut
);

  // R1
  clear_zero_chk: assert property (@(posedge clk)
    !clrN |-> countOut == '0);

  // R3
  preset_load_chk: assert property (@(posedge clk) disable iff (!clrN)
    !presetN |=> countOut == $past(loadVal));

  // R4
  shift_step_chk: assert property (@(posedge clk) disable iff (!clrN)
    presetN |=> countOut == {$past(countOut[WIDTH-2:0]), ~$past(countOut[WIDTH-1])});

  // R6
  legal_closed_chk: assert property (@(posedge clk) disable iff (!clrN)
    (presetN && $countones(countOut[WIDTH-1:1] ^ countOut[WIDTH-2:0]) <= 1)
    |=> $countones(countOut[WIDTH-1:1] ^ countOut[WIDTH-2:0]) <= 1);

endmodule

bind twisted_ring_counter twisted_ring_counter_chk #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .clrN     (clrN),
  .presetN  (presetN),
  .loadVal  (loadVal),
  .countOut (countOut)
);

// File: tb/twisted_ring_counter_tb_top.sv
module twisted_ring_counter_tb_top;

  localparam int W = 4;
  localparam int NVEC = 22;

  logic         clk = 1'b0;
  logic         clrN;
  logic         presetN;
  logic [W-1:0] loadVal;
  logic [W-1:0] countOut;

  int applied = 0;
  int bad = 0;

  // {presetN, loadVal, expected countOut after the edge}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b1, 4'h0, 4'b0001}, {1'b1, 4'h0, 4'b0011}, {1'b1, 4'h0, 4'b0111},
    {1'b1, 4'h0, 4'b1111}, {1'b1, 4'h0, 4'b1110}, {1'b1, 4'h0, 4'b1100},
    {1'b1, 4'h0, 4'b1000}, {1'b1, 4'h0, 4'b0000},
    {1'b0, 4'b0101, 4'b0101},
    {1'b1, 4'h0, 4'b1011}, {1'b1, 4'h0, 4'b0110}, {1'b1, 4'h0, 4'b1101},
    {1'b1, 4'h0, 4'b1010}, {1'b1, 4'h0, 4'b0100}, {1'b1, 4'h0, 4'b1001},
    {1'b1, 4'h0, 4'b0010}, {1'b1, 4'h0, 4'b0101},
    {1'b0, 4'b1100, 4'b1100}, {1'b0, 4'b0111, 4'b0111},
    {1'b1, 4'h0, 4'b1111},
    {1'b0, 4'b0011, 4'b0011}, {1'b1, 4'h0, 4'b0111}
  };

  twisted_ring_counter #(.WIDTH(W)) dut_i (
    .clk      (clk),
    .clrN     (clrN),
    .presetN  (presetN),
    .loadVal  (loadVal),
    .countOut (countOut)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] exp);
    applied++;
    if (countOut !== exp) begin
      bad++;
      $display("FAIL %s: countOut=%b expected=%b at %0t", req, countOut, exp, $time);
    end
  endtask

  // Advance one rising edge, then settle away from it
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    finishRun();
  end

  initial begin
    clrN = 1'b0;
    presetN = 1'b1;
    loadVal = '0;
    #1;
    check("R1 reset state", 4'b0000);
    tick();
    tick();
    check("R1 held clear", 4'b0000);
    #1;
    clrN = 1'b1;

    // Table walk: R5 and R6 (zero walk), R7 (illegal seed), R3 and R9 (preset), R4 (all shifts)
    for (int v = 0; v < NVEC; v++) begin
      presetN = VEC[v][8];
      loadVal = VEC[v][7:4];
      tick();
      check($sformatf("R4/R5/R6/R7/R3/R9 vector %0d", v), VEC[v][3:0]);
    end

    // R1: clear dropped mid-period clears without an edge
    presetN = 1'b1;
    tick();                         // 0111 -> 1111
    check("R4 before clear", 4'b1111);
    #1;
    clrN = 1'b0;
    #1;
    check("R1 mid-period clear", 4'b0000);

    // R2: clear outranks preset over several edges
    presetN = 1'b0;
    loadVal = 4'b1111;
    tick();
    check("R2 clear beats preset", 4'b0000);
    tick();
    check("R2 clear beats preset again", 4'b0000);

    // R8: release between edges, first shift gives 0001
    presetN = 1'b1;
    #1;
    clrN = 1'b1;
    tick();
    check("R8 first shift after clear", 4'b0001);
    tick();
    check("R8 second shift after clear", 4'b0011);

    // R9: held preset with changing word
    presetN = 1'b0;
    loadVal = 4'b1001;
    tick();
    check("R9 held preset a", 4'b1001);
    loadVal = 4'b0110;
    tick();
    check("R9 held preset b", 4'b0110);
    presetN = 1'b1;
    tick();
    check("R7 illegal seed shift", 4'b1101);

    finishRun();
  end

endmodule